// File: doc/BRIEF.md
# Split/Shared Peripheral Bus Lane Steering

This block sits between a bus master's internal transmit and receive word paths and a 64-bit bundle of data pads with eight active-low byte-enable pads. It produces registered pad output values and separate output enables for the upper and lower halves of both the data and the byte-enable pads. It also captures incoming words for the receive side.

A static configuration input picks one of two layouts. In full mode the whole bundle is one bidirectional bus. Writes drive all 64 bits and all eight byte enables, and reads sample all of them. In split mode the upper data half carries transmit data and is driven at all times, with byte enables [7:4] qualifying it. The lower data half carries receive data, with byte enables [3:0] qualifying it. The master drives the lower half only while the attached device is held in reset, or after a programmable number of idle cycles with no receive activity. It then drives a fixed fill value there until the next receive cycle. The layout is captured once after reset. Where two masters share one bus, the `SHARED_BUS` parameter removes the split variant, because split operation is not allowed on a shared bus.

Top module: `bus_lane_steer`

## Requirements
- R1: During reset, every pad output enable is 0, `pad_dout` is 0, `be_dout` is all ones and `rx_valid` is 0.
- R2: The layout is taken from `cfg_split` (0 = full, 1 = split) at the first clock edge after reset is released. Later changes of `cfg_split` have no effect until the next reset. Changing it while a transfer is active on two consecutive cycles is flagged.
- R3: In full mode, a cycle with `tx_valid` high makes the next edge drive `pad_dout = tx_data` and `be_dout = tx_be_n`, with all four output enables at 1. Enable and data change on the same edge.
- R4: In full mode, a cycle with `tx_valid` low gives all four output enables 0 after the next edge. A cycle with `rx_active` high gives `rx_valid = 1`, `rx_data = pad_din` and `rx_be_n = be_din` after the next edge. `tx_valid` and `rx_active` must not both be high.
- R5: In split mode, `pad_oe_hi` and `be_oe_hi` are 1 after every edge. `pad_dout[63:32]` is `tx_data[31:0]` and `be_dout[7:4]` is `tx_be_n[3:0]` after an edge that sampled `tx_valid` high. Otherwise they are 0 and 4'hF.
- R6: In split mode, a receive cycle captures `rx_data = {32'h0, pad_din[31:0]}` and `rx_be_n = {4'hF, be_din[3:0]}`. `be_oe_lo` stays 0.
- R7: In split mode, a cycle with `dev_reset` high and `rx_active` low makes the next edge set `pad_oe_lo = 1` and `pad_dout[31:0] = IDLE_FILL` (default all ones). A cycle with `rx_active` high always gives `pad_oe_lo = 0` and `pad_dout[31:0] = 0`.
- R8: In split mode, an idle counter clears on each cycle with `rx_active` high and counts the other cycles. `pad_oe_lo` goes to 1 at the edge that samples the `idle_limit`-th consecutive idle cycle, and returns to 0 at the edge that samples `rx_active` high.
- R9: With `SHARED_BUS = 1`, the block always behaves in full mode whatever `cfg_split` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_split | input | 1 | Layout select: 0 full bidirectional, 1 split |
| idle_limit | input | 16 | Idle cycles before the lower half is driven in split mode |
| dev_reset | input | 1 | Device held in reset; the lower half is driven in split mode |
| tx_valid | input | 1 | Transmit word present this cycle |
| tx_data | input | 64 | Transmit word (split mode uses bits [31:0]) |
| tx_be_n | input | 8 | Transmit byte enables, active low (split mode uses [3:0]) |
| rx_active | input | 1 | This cycle is a receive cycle |
| rx_valid | output | 1 | Captured receive word valid |
| rx_data | output | 64 | Captured receive word |
| rx_be_n | output | 8 | Captured receive byte enables, active low |
| pad_dout | output | 64 | Data pad output values |
| pad_din | input | 64 | Data pad input values |
| pad_oe_hi | output | 1 | Output enable, data bits [63:32] |
| pad_oe_lo | output | 1 | Output enable, data bits [31:0] |
| be_dout | output | 8 | Byte-enable pad output values |
| be_din | input | 8 | Byte-enable pad input values |
| be_oe_hi | output | 1 | Output enable, byte enables [7:4] |
| be_oe_lo | output | 1 | Output enable, byte enables [3:0] |

## Verification
In full mode the block is given writes with distinct data and byte-enable patterns, an idle cycle and a read. These show whether both halves turn on and off together with the data. In split mode the same distinct patterns show whether transmit data lands in the upper half and receive bits come only from the lower half. The cases that set the lower-half driving rule apart are a device-reset cycle, an idle run that stops one cycle short of the limit and then reaches it, and a receive cycle that releases the half. Toggling the layout input between resets, and a second instance built for a shared bus, show that the layout is latched once and that the split variant can be removed.

// File: rtl/bls_pkg.sv
package bls_pkg;
   typedef enum logic {
      BUS_FULL  = 1'b0,
      BUS_SPLIT = 1'b1
   } bus_mode_e;
endpackage

// File: rtl/bls_mode_latch.sv
module bls_mode_latch
   import bls_pkg::*;
#(
   parameter bit SHARED_BUS = 1'b0
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      cfg_split,
   output bus_mode_e mode_o
);
   logic      armed_q;
   bus_mode_e mode_q;
   bus_mode_e live_mode;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         mode_q  <= BUS_FULL;
      end else if (!armed_q) begin
         armed_q <= 1'b1;
         mode_q  <= bus_mode_e'(cfg_split);
      end
   end

   // Before the first edge the live input decides, afterwards the captured copy.
   assign live_mode = armed_q ? mode_q : bus_mode_e'(cfg_split);

   generate
      if (SHARED_BUS) begin : g_shared
         assign mode_o = BUS_FULL;
      end else begin : g_private
         assign mode_o = live_mode;
      end
   endgenerate

   // R2: once captured the mode does not move until reset
   a_r2_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      armed_q |=> $stable(mode_q));
endmodule

// File: rtl/bls_idle_timer.sv
module bls_idle_timer #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_active,
   input  logic [CNT_W-1:0] limit,
   output logic             hit_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_d;

   always_comb begin
      if (rx_active)
         cnt_d = '0;
      else if (cnt_q == CNT_MAX)
         cnt_d = cnt_q;
      else
         cnt_d = cnt_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
   end

   assign hit_o = !rx_active && (cnt_d >= limit);

   // R8: a receive cycle clears the count
   a_r8_count_clears: assert property (@(posedge clk) disable iff (!rst_n)
      rx_active |=> (cnt_q == '0));
   // R8: the count never wraps back to zero while idle
   a_r8_count_saturates: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_active && cnt_q != '0) |=> (cnt_q != '0));
endmodule

// File: rtl/bls_tx_steer.sv
module bls_tx_steer
   import bls_pkg::*;
#(
   parameter int unsigned          DATA_W    = 64,
   parameter logic [DATA_W/2-1:0]  IDLE_FILL = '1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  bus_mode_e           mode,
   input  logic                tx_valid,
   input  logic [DATA_W-1:0]   tx_data,
   input  logic [DATA_W/8-1:0] tx_be_n,
   input  logic                rx_active,
   input  logic                dev_reset,
   input  logic                idle_hit,
   output logic [DATA_W-1:0]   pad_dout,
   output logic                pad_oe_hi,
   output logic                pad_oe_lo,
   output logic [DATA_W/8-1:0] be_dout,
   output logic                be_oe_hi,
   output logic                be_oe_lo
);
   localparam int unsigned HALF_W  = DATA_W / 2;
   localparam int unsigned BE_W    = DATA_W / 8;
   localparam int unsigned HALF_BE = BE_W / 2;

   logic [DATA_W-1:0] dout_d;
   logic [BE_W-1:0]   be_d;
   logic              oe_hi_d, oe_lo_d, be_hi_d, be_lo_d;
   logic              drive_lo;

   assign drive_lo = !rx_active && (dev_reset || idle_hit);

   always_comb begin
      dout_d  = '0;
      be_d    = '1;
      oe_hi_d = 1'b0;
      oe_lo_d = 1'b0;
      be_hi_d = 1'b0;
      be_lo_d = 1'b0;
      if (mode == BUS_SPLIT) begin
         oe_hi_d = 1'b1;
         be_hi_d = 1'b1;
         if (tx_valid) begin
            dout_d[DATA_W-1:HALF_W] = tx_data[HALF_W-1:0];
            be_d[BE_W-1:HALF_BE]    = tx_be_n[HALF_BE-1:0];
         end
         if (drive_lo) begin
            oe_lo_d               = 1'b1;
            dout_d[HALF_W-1:0]    = IDLE_FILL;
         end
      end else if (tx_valid) begin
         oe_hi_d = 1'b1;
         oe_lo_d = 1'b1;
         be_hi_d = 1'b1;
         be_lo_d = 1'b1;
         dout_d  = tx_data;
         be_d    = tx_be_n;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pad_dout  <= '0;
         be_dout   <= '1;
         pad_oe_hi <= 1'b0;
         pad_oe_lo <= 1'b0;
         be_oe_hi  <= 1'b0;
         be_oe_lo  <= 1'b0;
      end else begin
         pad_dout  <= dout_d;
         be_dout   <= be_d;
         pad_oe_hi <= oe_hi_d;
         pad_oe_lo <= oe_lo_d;
         be_oe_hi  <= be_hi_d;
         be_oe_lo  <= be_lo_d;
      end
   end

   // R3: a full-mode write turns on all four enables together
   a_r3_full_write_all_on: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == BUS_FULL && tx_valid) |=> (pad_oe_hi && pad_oe_lo && be_oe_hi && be_oe_lo));
   // R4: full mode without a write releases the pads
   a_r4_full_idle_off: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == BUS_FULL && !tx_valid) |=> !(pad_oe_hi || pad_oe_lo || be_oe_hi || be_oe_lo));
   // R5: split mode keeps the transmit half driven
   a_r5_tx_half_driven: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == BUS_SPLIT) |=> (pad_oe_hi && be_oe_hi));
   // R6: split mode never drives the low byte enables
   a_r6_be_lo_input: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == BUS_SPLIT) |=> !be_oe_lo);
   // R7: a receive cycle frees the low data half
   a_r7_rx_frees_lo: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == BUS_SPLIT && rx_active) |=> !pad_oe_lo);
endmodule

// File: rtl/bls_rx_capture.sv
module bls_rx_capture
   import bls_pkg::*;
#(
   parameter int unsigned DATA_W = 64
) (
   input  logic                clk,
   input  logic                rst_n,
   input  bus_mode_e           mode,
   input  logic                rx_active,
   input  logic [DATA_W-1:0]   pad_din,
   input  logic [DATA_W/8-1:0] be_din,
   output logic                rx_valid,
   output logic [DATA_W-1:0]   rx_data,
   output logic [DATA_W/8-1:0] rx_be_n
);
   localparam int unsigned HALF_W  = DATA_W / 2;
   localparam int unsigned BE_W    = DATA_W / 8;
   localparam int unsigned HALF_BE = BE_W / 2;

   logic [DATA_W-1:0] data_d;
   logic [BE_W-1:0]   be_d;

   always_comb begin
      if (mode == BUS_SPLIT) begin
         data_d = {{HALF_W{1'b0}}, pad_din[HALF_W-1:0]};
         be_d   = {{HALF_BE{1'b1}}, be_din[HALF_BE-1:0]};
      end else begin
         data_d = pad_din;
         be_d   = be_din;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_valid <= 1'b0;
         rx_data  <= '0;
         rx_be_n  <= '1;
      end else begin
         rx_valid <= rx_active;
         if (rx_active) begin
            rx_data <= data_d;
            rx_be_n <= be_d;
         end
      end
   end

   // R4: a receive cycle yields a valid word on the next edge, nothing else does
   a_r4_rx_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      rx_active |=> rx_valid);
   a_r4_rx_valid_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_active |=> !rx_valid);
endmodule

// File: rtl/bus_lane_steer.sv
module bus_lane_steer
   import bls_pkg::*;
#(
   parameter int unsigned          DATA_W     = 64,
   parameter int unsigned          IDLE_CNT_W = 16,
   parameter bit                   SHARED_BUS = 1'b0,
   parameter logic [DATA_W/2-1:0]  IDLE_FILL  = '1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cfg_split,
   input  logic [IDLE_CNT_W-1:0] idle_limit,
   input  logic                  dev_reset,
   input  logic                  tx_valid,
   input  logic [DATA_W-1:0]     tx_data,
   input  logic [DATA_W/8-1:0]   tx_be_n,
   input  logic                  rx_active,
   output logic                  rx_valid,
   output logic [DATA_W-1:0]     rx_data,
   output logic [DATA_W/8-1:0]   rx_be_n,
   output logic [DATA_W-1:0]     pad_dout,
   input  logic [DATA_W-1:0]     pad_din,
   output logic                  pad_oe_hi,
   output logic                  pad_oe_lo,
   output logic [DATA_W/8-1:0]   be_dout,
   input  logic [DATA_W/8-1:0]   be_din,
   output logic                  be_oe_hi,
   output logic                  be_oe_lo
);
   generate
      if (DATA_W % 16 != 0 || DATA_W < 16) begin : g_bad_width
         $error("DATA_W must be a multiple of 16 so each half holds whole bytes");
      end
      if (IDLE_CNT_W < 1) begin : g_bad_cnt
         $error("IDLE_CNT_W must be at least 1");
      end
   endgenerate

   bus_mode_e mode;
   logic      idle_hit;
   logic      busy;

   bls_mode_latch #(.SHARED_BUS(SHARED_BUS)) u_mode (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_split (cfg_split),
      .mode_o    (mode)
   );

   bls_idle_timer #(.CNT_W(IDLE_CNT_W)) u_idle (
      .clk       (clk),
      .rst_n     (rst_n),
      .rx_active (rx_active),
      .limit     (idle_limit),
      .hit_o     (idle_hit)
   );

   bls_tx_steer #(.DATA_W(DATA_W), .IDLE_FILL(IDLE_FILL)) u_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode      (mode),
      .tx_valid  (tx_valid),
      .tx_data   (tx_data),
      .tx_be_n   (tx_be_n),
      .rx_active (rx_active),
      .dev_reset (dev_reset),
      .idle_hit  (idle_hit),
      .pad_dout  (pad_dout),
      .pad_oe_hi (pad_oe_hi),
      .pad_oe_lo (pad_oe_lo),
      .be_dout   (be_dout),
      .be_oe_hi  (be_oe_hi),
      .be_oe_lo  (be_oe_lo)
   );

   bls_rx_capture #(.DATA_W(DATA_W)) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode      (mode),
      .rx_active (rx_active),
      .pad_din   (pad_din),
      .be_din    (be_din),
      .rx_valid  (rx_valid),
      .rx_data   (rx_data),
      .rx_be_n   (rx_be_n)
   );

   assign busy = tx_valid || rx_active;

   // R2: the layout input must hold still while traffic runs
   a_r2_no_mode_change_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(cfg_split));
   // R4: a full-mode bus cannot write and read in the same cycle
   a_r4_no_full_clash: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == BUS_FULL) |-> !(tx_valid && rx_active));
   // R9: a shared-bus build never leaves full mode
   a_r9_shared_full_only: assert property (@(posedge clk) disable iff (!rst_n)
      SHARED_BUS |-> (mode == BUS_FULL));
endmodule

// File: tb/sim_bus_lane_steer.sv
`timescale 1ns/1ps
module sim_bus_lane_steer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_split = 1'b0;
   logic [15:0] idle_limit = 16'hFFFF;
   logic        dev_reset = 1'b0;
   logic        tx_valid = 1'b0;
   logic [63:0] tx_data = '0;
   logic [7:0]  tx_be_n = '1;
   logic        rx_active = 1'b0;
   logic [63:0] pad_din = '0;
   logic [7:0]  be_din = '1;
   logic        rx_valid, pad_oe_hi, pad_oe_lo, be_oe_hi, be_oe_lo;
   logic [63:0] rx_data, pad_dout;
   logic [7:0]  rx_be_n, be_dout;
   logic        s_tx_valid = 1'b0;
   logic        s_rx_valid, s_oe_hi, s_oe_lo, s_be_hi, s_be_lo;
   logic [63:0] s_rx_data, s_dout;
   logic [7:0]  s_rx_be, s_be_dout;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   bus_lane_steer u0 (
      .clk(clk), .rst_n(rst_n), .cfg_split(cfg_split), .idle_limit(idle_limit),
      .dev_reset(dev_reset), .tx_valid(tx_valid), .tx_data(tx_data), .tx_be_n(tx_be_n),
      .rx_active(rx_active), .rx_valid(rx_valid), .rx_data(rx_data), .rx_be_n(rx_be_n),
      .pad_dout(pad_dout), .pad_din(pad_din), .pad_oe_hi(pad_oe_hi), .pad_oe_lo(pad_oe_lo),
      .be_dout(be_dout), .be_din(be_din), .be_oe_hi(be_oe_hi), .be_oe_lo(be_oe_lo)
   );

   bus_lane_steer #(.SHARED_BUS(1'b1)) u1 (
      .clk(clk), .rst_n(rst_n), .cfg_split(cfg_split), .idle_limit(idle_limit),
      .dev_reset(dev_reset), .tx_valid(s_tx_valid), .tx_data(tx_data), .tx_be_n(tx_be_n),
      .rx_active(1'b0), .rx_valid(s_rx_valid), .rx_data(s_rx_data), .rx_be_n(s_rx_be),
      .pad_dout(s_dout), .pad_din(pad_din), .pad_oe_hi(s_oe_hi), .pad_oe_lo(s_oe_lo),
      .be_dout(s_be_dout), .be_din(be_din), .be_oe_hi(s_be_hi), .be_oe_lo(s_be_lo)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic chk_eq(input string req, input logic [63:0] act, input logic [63:0] exp);
      chk(act === exp, req, act, exp);
   endtask

   task automatic idle_inputs();
      tx_valid = 1'b0; rx_active = 1'b0; dev_reset = 1'b0; s_tx_valid = 1'b0;
      tx_data = '0; tx_be_n = '1; pad_din = '0; be_din = '1;
   endtask

   task automatic do_reset(input logic split);
      @(negedge clk);
      rst_n = 1'b0;
      cfg_split = split;
      idle_inputs();
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_reset_state();
      @(negedge clk);
      rst_n = 1'b0;
      idle_inputs();
      @(negedge clk);
      chk_eq("R1 oe during reset", {60'h0, pad_oe_hi, pad_oe_lo, be_oe_hi, be_oe_lo}, 64'h0);
      chk_eq("R1 pad_dout during reset", pad_dout, 64'h0);
      chk_eq("R1 be_dout/rx_valid during reset", {55'h0, be_dout, rx_valid}, {55'h0, 8'hFF, 1'b0});
      rst_n = 1'b1;
   endtask

   task automatic t_full_write();
      do_reset(1'b0);
      tx_valid = 1'b1; tx_data = 64'hDEAD_BEEF_0123_4567; tx_be_n = 8'h3C;
      @(negedge clk);
      chk_eq("R3 write data", pad_dout, 64'hDEAD_BEEF_0123_4567);
      chk_eq("R3 write be", {56'h0, be_dout}, {56'h0, 8'h3C});
      chk_eq("R3 write oe", {60'h0, pad_oe_hi, pad_oe_lo, be_oe_hi, be_oe_lo}, 64'hF);
      tx_data = 64'h0F0F_A5A5_F0F0_5A5A; tx_be_n = 8'h00;
      @(negedge clk);
      chk_eq("R3 second write", {pad_dout[63:8], be_dout}, {56'h0F0F_A5A5_F0F0_5A, 8'h00});
      tx_valid = 1'b0;
      @(negedge clk);
      chk_eq("R4 idle releases pads", {60'h0, pad_oe_hi, pad_oe_lo, be_oe_hi, be_oe_lo}, 64'h0);
   endtask

   task automatic t_full_read();
      rx_active = 1'b1; pad_din = 64'h1122_3344_5566_7788; be_din = 8'hA5;
      @(negedge clk);
      rx_active = 1'b0; pad_din = 64'hFFFF_0000_FFFF_0000;
      chk_eq("R4 read valid", {63'h0, rx_valid}, 64'h1);
      chk_eq("R4 read full word", rx_data, 64'h1122_3344_5566_7788);
      chk_eq("R4 read be", {56'h0, rx_be_n}, {56'h0, 8'hA5});
      chk_eq("R4 read leaves pads released", {62'h0, pad_oe_hi, pad_oe_lo}, 64'h0);
      @(negedge clk);
      chk_eq("R4 no receive no valid", {63'h0, rx_valid}, 64'h0);
   endtask

   task automatic t_mode_hold();
      cfg_split = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk_eq("R2 late cfg change ignored", {63'h0, pad_oe_hi}, 64'h0);
      do_reset(1'b1);
      @(negedge clk);
      chk_eq("R2 cfg taken after reset", {62'h0, pad_oe_hi, be_oe_hi}, 64'h3);
      cfg_split = 1'b0;
      @(negedge clk);
      chk_eq("R2 split kept after cfg drop", {62'h0, pad_oe_hi, be_oe_hi}, 64'h3);
   endtask

   task automatic t_split_tx();
      tx_valid = 1'b1; tx_data = 64'h9999_9999_CAFE_F00D; tx_be_n = 8'hF6;
      @(negedge clk);
      chk_eq("R5 tx in upper half", pad_dout[63:32], 64'hCAFE_F00D);
      chk_eq("R5 tx be in upper nibble", {60'h0, be_dout[7:4]}, 64'h6);
      chk_eq("R5/R6 enables", {60'h0, pad_oe_hi, pad_oe_lo, be_oe_hi, be_oe_lo}, 64'b1010);
      tx_valid = 1'b0;
      @(negedge clk);
      chk_eq("R5 idle tx half", {pad_dout[63:32], 24'h0, be_dout[7:4], 3'h0, pad_oe_hi},
             {32'h0, 24'h0, 4'hF, 3'h0, 1'b1});
   endtask

   task automatic t_split_rx();
      tx_valid = 1'b1; tx_data = 64'h0000_0000_1357_9BDF; tx_be_n = 8'h01;
      rx_active = 1'b1; pad_din = 64'hAAAA_BBBB_2468_ACE0; be_din = 8'h5C;
      @(negedge clk);
      rx_active = 1'b0; tx_valid = 1'b0;
      chk_eq("R6 split rx low bits only", rx_data, 64'h0000_0000_2468_ACE0);
      chk_eq("R6 split rx be", {56'h0, rx_be_n}, {56'h0, 8'hFC});
      chk_eq("R5 tx during rx", pad_dout[63:32], 64'h1357_9BDF);
      chk_eq("R7 lo free during rx", {63'h0, pad_oe_lo}, 64'h0);
   endtask

   task automatic t_dev_reset();
      idle_limit = 16'hFFFF;
      dev_reset = 1'b1;
      @(negedge clk);
      chk_eq("R7 dev reset drives lo", {63'h0, pad_oe_lo}, 64'h1);
      chk_eq("R7 dev reset fill", pad_dout[31:0], 64'hFFFF_FFFF);
      rx_active = 1'b1;
      @(negedge clk);
      chk_eq("R7 rx overrides dev reset", {31'h0, pad_oe_lo, pad_dout[31:0]}, 64'h0);
      rx_active = 1'b0; dev_reset = 1'b0;
      @(negedge clk);
      chk_eq("R7 dev reset gone", {63'h0, pad_oe_lo}, 64'h0);
   endtask

   task automatic t_idle_timer();
      idle_limit = 16'd3;
      rx_active = 1'b1;
      @(negedge clk);
      rx_active = 1'b0;
      @(negedge clk);
      @(negedge clk);
      chk_eq("R8 two idle cycles short of limit", {63'h0, pad_oe_lo}, 64'h0);
      @(negedge clk);
      chk_eq("R8 limit reached drives lo", {31'h0, pad_oe_lo, pad_dout[31:0]}, {31'h0, 1'b1, 32'hFFFF_FFFF});
      @(negedge clk);
      chk_eq("R8 lo stays driven", {63'h0, pad_oe_lo}, 64'h1);
      rx_active = 1'b1;
      @(negedge clk);
      rx_active = 1'b0;
      chk_eq("R8 receive releases lo", {63'h0, pad_oe_lo}, 64'h0);
      @(negedge clk);
      chk_eq("R8 count restarted", {63'h0, pad_oe_lo}, 64'h0);
      idle_limit = 16'hFFFF;
   endtask

   task automatic t_shared();
      do_reset(1'b1);
      @(negedge clk);
      chk_eq("R9 shared build ignores split", {62'h0, s_oe_hi, s_be_hi}, 64'h0);
      s_tx_valid = 1'b1; tx_data = 64'h0102_0304_0506_0708; tx_be_n = 8'h0F;
      @(negedge clk);
      s_tx_valid = 1'b0;
      chk_eq("R9 shared full write", s_dout, 64'h0102_0304_0506_0708);
      chk_eq("R9 shared all enables", {60'h0, s_oe_hi, s_oe_lo, s_be_hi, s_be_lo}, 64'hF);
   endtask

   initial begin
      do_reset(1'b0);
      t_reset_state();
      t_full_write();
      t_full_read();
      t_mode_hold();
      t_split_tx();
      t_split_rx();
      t_dev_reset();
      t_idle_timer();
      t_shared();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      #200000;
      if (!done) begin
         done = 1'b1;
         errors++;
         checks++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule